// File: doc/BRIEF.md
# Sample Limiter with Overload Hold Flag

This block sits at the end of a stereo decimation chain. It receives one wide signed sample per channel with a strobe, limits each to an 18-bit two's-complement range, and registers the results for the serial output stage. It also raises a flag when a sample comes close to full scale.

The comparison works on the magnitude of the already-limited sample against a fixed count just below full scale. When either channel goes above that count, the flag rises and stays high for a fixed number of system clocks. Every later crossing restarts that window. A standby input pulls the flag low at once and clears the window. Crossings that arrive during standby are ignored.

Top module: `smp_limit_ovl`

## Requirements
- R1: When a strobed sample is above +131071, its output becomes +131071 on the clock edge where the strobe is sampled.
- R2: When a strobed sample is below -131072, its output becomes -131072 on that edge.
- R3: A strobed sample inside [-131072, +131071] appears unchanged on its output on that edge.
- R4: On edges without a strobe, both sample outputs keep their values.
- R5: A strobed left sample whose limited magnitude is above THRESH (default 116500) sets the flag on that edge.
- R6: The right channel sets the flag under the same rule, including for negative samples.
- R7: A limited magnitude exactly equal to THRESH does not set the flag. THRESH+1 does set it.
- R8: After a crossing and with no further crossing, the flag stays high for exactly HOLD_CLKS clocks (default 131072) and then falls.
- R9: A crossing while the flag is high restarts the full HOLD_CLKS window.
- R10: While standby is high the flag is low and crossings are ignored. After standby falls, the flag stays low until a new crossing.
- R11: Synchronous active-low reset clears both sample outputs to 0 and the flag to 0.
- R12: A sample limited by R1 or R2 always sets the flag.
- R13: A sample of exactly -131072 sets the flag. Its magnitude is computed without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe marking a new sample pair |
| standby | input | 1 | High forces the flag low and clears the hold window |
| in_l | input | IN_W | Wide signed left sample from the filter chain |
| in_r | input | IN_W | Wide signed right sample from the filter chain |
| out_l | output | OUT_W | Limited signed left sample |
| out_r | output | OUT_W | Limited signed right sample |
| ovl_flag | output | 1 | Near-full-scale indicator with retriggerable hold |

## Verification
The hardest situation to reach is the last clock of the hold window. The flag must still be high one cycle before expiry and low exactly one cycle later, and a retrigger must land on the cycle just before expiry. At the default hold length this takes over a hundred thousand clocks per case. The bench therefore overrides HOLD_CLKS with a short value and counts clock edges from the strobe to reach each boundary exactly. Standby is pulsed between scenarios so that every threshold case starts from a known low flag.

// File: rtl/smp_limit_pkg.sv
// Package: shared constants for the stereo sample limiter.
// Assumes two channels, index 0 = left, 1 = right.
package smp_limit_pkg;
    localparam int CH_COUNT = 2;
    localparam int CH_LEFT  = 0;
    localparam int CH_RIGHT = 1;
endpackage

// File: rtl/smp_sat.sv
// Module: smp_sat
// Limits a wide signed sample to the OUT_W-bit two's-complement range.
// Purely combinational. Assumes IN_W > OUT_W.
module smp_sat #(
    parameter int IN_W  = 24,
    parameter int OUT_W = 18
) (
    input  logic signed [IN_W-1:0]  din,
    output logic signed [OUT_W-1:0] dout
);
    localparam logic signed [IN_W-1:0] MAXV = IN_W'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [IN_W-1:0] MINV = ~MAXV;

    // Select the upper limit, the lower limit or the sample itself.
    always_comb begin
        if (din > MAXV)
            dout = MAXV[OUT_W-1:0];
        else if (din < MINV)
            dout = MINV[OUT_W-1:0];
        else
            dout = din[OUT_W-1:0];
    end
endmodule

// File: rtl/lvl_cmp.sv
// Module: lvl_cmp
// Reports whether the magnitude of a limited sample is above THRESH.
// The magnitude uses one extra bit, so the most negative value is safe.
module lvl_cmp #(
    parameter int OUT_W  = 18,
    parameter int THRESH = 116500
) (
    input  logic signed [OUT_W-1:0] din,
    output logic                    over
);
    localparam int MAG_W = OUT_W + 1;
    localparam logic [MAG_W-1:0] THR = MAG_W'(THRESH);

    logic [MAG_W-1:0] ext;
    logic [MAG_W-1:0] mag;

    // Sign-extend, take the absolute value, then compare unsigned.
    always_comb begin
        ext  = {din[OUT_W-1], din};
        mag  = din[OUT_W-1] ? (~ext + 1'b1) : ext;
        over = (mag > THR);
    end
endmodule

// File: rtl/ovl_hold.sv
// Module: ovl_hold
// Retriggerable hold timer. A trigger loads HOLD_CLKS. The count then
// falls by one per clock, and the flag is high while the count is nonzero.
// Standby clears the count and masks the flag at once.
module ovl_hold #(
    parameter int HOLD_CLKS = 131072
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic standby,
    output logic flag
);
    localparam int CNT_W = $clog2(HOLD_CLKS + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD_CLKS);

    logic [CNT_W-1:0] cnt;

    // Count register: clear, reload on a crossing, or count down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (standby)
            cnt <= '0;
        else if (trig)
            cnt <= LOAD;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // Flag: nonzero count, masked by standby.
    assign flag = (cnt != '0) && !standby;
endmodule

// File: rtl/smp_limit_ovl.sv
// Module: smp_limit_ovl (top)
// Limits each strobed stereo sample to OUT_W bits, registers the result,
// and drives a retriggerable near-full-scale flag. The threshold is
// applied to the limited value, so a limited sample always triggers.
module smp_limit_ovl
    import smp_limit_pkg::*;
#(
    parameter int IN_W      = 24,
    parameter int OUT_W     = 18,
    parameter int THRESH    = 116500,
    parameter int HOLD_CLKS = 131072
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic                    standby,
    input  logic signed [IN_W-1:0]  in_l,
    input  logic signed [IN_W-1:0]  in_r,
    output logic signed [OUT_W-1:0] out_l,
    output logic signed [OUT_W-1:0] out_r,
    output logic                    ovl_flag
);
    logic signed [IN_W-1:0]  raw  [CH_COUNT];
    logic signed [OUT_W-1:0] clip [CH_COUNT];
    logic [CH_COUNT-1:0]     over;
    logic                    trig;

    assign raw[CH_LEFT]  = in_l;
    assign raw[CH_RIGHT] = in_r;

    // One limiter and one comparator per channel.
    for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_ch
        smp_sat #(.IN_W(IN_W), .OUT_W(OUT_W)) u_sat (
            .din  (raw[ch]),
            .dout (clip[ch])
        );
        lvl_cmp #(.OUT_W(OUT_W), .THRESH(THRESH)) u_cmp (
            .din  (clip[ch]),
            .over (over[ch])
        );
    end

    // Output registers: capture the limited samples on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_l <= '0;
            out_r <= '0;
        end else if (smp_valid) begin
            out_l <= clip[CH_LEFT];
            out_r <= clip[CH_RIGHT];
        end
    end

    assign trig = smp_valid && (|over);

    ovl_hold #(.HOLD_CLKS(HOLD_CLKS)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (trig),
        .standby (standby),
        .flag    (ovl_flag)
    );
endmodule

// File: rtl/smp_limit_ovl_chk.sv
// Module: smp_limit_ovl_chk
// Port-level properties for smp_limit_ovl, attached with bind.
module smp_limit_ovl_chk #(
    parameter int IN_W      = 24,
    parameter int OUT_W     = 18,
    parameter int THRESH    = 116500,
    parameter int HOLD_CLKS = 131072
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    smp_valid,
    input logic                    standby,
    input logic signed [IN_W-1:0]  in_l,
    input logic signed [IN_W-1:0]  in_r,
    input logic signed [OUT_W-1:0] out_l,
    input logic signed [OUT_W-1:0] out_r,
    input logic                    ovl_flag
);
    localparam logic signed [IN_W-1:0]  WMAX = IN_W'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [IN_W-1:0]  WMIN = ~WMAX;
    localparam logic signed [IN_W-1:0]  WTHR = IN_W'(THRESH);
    localparam logic signed [OUT_W-1:0] OMAX = WMAX[OUT_W-1:0];
    localparam logic signed [OUT_W-1:0] OMIN = WMIN[OUT_W-1:0];

    assert_clip_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && (in_l > WMAX)) |=> (out_l == OMAX));

    assert_clip_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && (in_r < WMIN)) |=> (out_r == OMIN));

    assert_hold_outputs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ($stable(out_l) && $stable(out_r)));

    assert_left_trigger_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !standby && (in_l > WTHR)) |=> (ovl_flag || standby));

    assert_standby_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> !ovl_flag);
endmodule

bind smp_limit_ovl smp_limit_ovl_chk #(
    .IN_W(IN_W), .OUT_W(OUT_W), .THRESH(THRESH), .HOLD_CLKS(HOLD_CLKS)
) u_chk (.*);

// File: tb/sim_smp_limit_ovl.sv
// Directed bench for smp_limit_ovl. The hold window is shortened.
module sim_smp_limit_ovl;
    localparam int IN_W = 24;
    localparam int OUT_W = 18;
    localparam int THR = 116500;
    localparam int HOLD = 200;
    localparam int PMAX = 131071;
    localparam int PMIN = -131072;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic standby = 1'b0;
    logic signed [IN_W-1:0] in_l = '0;
    logic signed [IN_W-1:0] in_r = '0;
    logic signed [OUT_W-1:0] out_l;
    logic signed [OUT_W-1:0] out_r;
    logic ovl_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    smp_limit_ovl #(.IN_W(IN_W), .OUT_W(OUT_W), .THRESH(THR), .HOLD_CLKS(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .standby(standby),
        .in_l(in_l), .in_r(in_r), .out_l(out_l), .out_r(out_r), .ovl_flag(ovl_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present one strobed pair at a falling edge; return after the next rising edge.
    task automatic send(input int l, input int r);
        in_l = IN_W'(l);
        in_r = IN_W'(r);
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic clear_flag();
        standby = 1'b1;
        @(negedge clk);
        standby = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R11 out_l", int'(out_l), 0);
        chk("R11 out_r", int'(out_r), 0);
        chk("R11 flag", int'(ovl_flag), 0);
    endtask

    task automatic t_pass_and_hold();
        send(1234, -5678);
        chk("R3 out_l", int'(out_l), 1234);
        chk("R3 out_r", int'(out_r), -5678);
        chk("R3 flag", int'(ovl_flag), 0);
        in_l = IN_W'(99999); in_r = IN_W'(-99999);
        repeat (3) @(negedge clk);
        chk("R4 out_l", int'(out_l), 1234);
        chk("R4 out_r", int'(out_r), -5678);
    endtask

    task automatic t_clip();
        clear_flag();
        send(8388607, -8388608);
        chk("R1 out_l", int'(out_l), PMAX);
        chk("R2 out_r", int'(out_r), PMIN);
        chk("R12 flag", int'(ovl_flag), 1);
        clear_flag();
        send(200000, 0);
        chk("R1 out_l", int'(out_l), PMAX);
        chk("R12 flag", int'(ovl_flag), 1);
    endtask

    task automatic t_threshold();
        clear_flag();
        send(THR, 0);
        chk("R7 at thresh left", int'(ovl_flag), 0);
        send(0, -THR);
        chk("R7 at thresh right", int'(ovl_flag), 0);
        send(THR + 1, 0);
        chk("R5 left over", int'(ovl_flag), 1);
        clear_flag();
        send(0, -(THR + 1));
        chk("R6 right negative", int'(ovl_flag), 1);
        clear_flag();
        send(0, PMIN);
        chk("R13 out_r", int'(out_r), PMIN);
        chk("R13 flag", int'(ovl_flag), 1);
    endtask

    task automatic t_hold_len();
        clear_flag();
        send(PMAX, 0);
        repeat (HOLD - 1) @(negedge clk);
        chk("R8 last high", int'(ovl_flag), 1);
        @(negedge clk);
        chk("R8 expired", int'(ovl_flag), 0);
    endtask

    task automatic t_retrigger();
        clear_flag();
        send(0, PMAX);
        repeat (HOLD - 2) @(negedge clk);
        send(0, -120000);
        repeat (HOLD - 1) @(negedge clk);
        chk("R9 still high", int'(ovl_flag), 1);
        @(negedge clk);
        chk("R9 expired", int'(ovl_flag), 0);
    endtask

    task automatic t_standby();
        clear_flag();
        send(PMAX, 0);
        standby = 1'b1;
        #1;
        chk("R10 immediate low", int'(ovl_flag), 0);
        @(negedge clk);
        send(PMAX, PMIN);
        chk("R10 ignored", int'(ovl_flag), 0);
        standby = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 after release", int'(ovl_flag), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_pass_and_hold();
        t_clip();
        t_threshold();
        t_hold_len();
        t_retrigger();
        t_standby();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule